// File: doc/BRIEF.md
# Sequential Write Posting Buffer

This block sits between a fast host write channel and a slower local drain channel. It queues posted 32-bit writes so that the host can move on before the local side has taken the data. The queue holds eight entries. Each entry keeps the write address together with the data, so every word leaves the drain port with the local address it was written to.

The host side can keep posting writes only while they form one unbroken run. A run is a series of addresses that step by four bytes and stay inside one naturally aligned region. A write that breaks the run is held off until every queued word has drained, and the run then restarts at that write. When the posting enable is low, the block holds at most one word. The host write completes only after the local side has taken that word.

Top module: `wpost_buffer`

## Requirements
- R1: The queue holds at most 8 entries, each a 32-bit address with 32-bit data. When 8 are queued, the host sees `host_ready` low until a word drains, even for a sequential write.
- R2: With posting on and room in the queue, a sequential write sees `host_ready` high in the same cycle. A burst of sequential writes is therefore taken on consecutive clocks.
- R3: A write counts as sequential only if its address equals the previous accepted address plus 4 and its `host_region` equals the previous write's region index.
- R4: Region r has a size of 2^L bytes, where L is the 5-bit field `region_lg[5r+4:5r]`, and it is aligned to that size. A write whose address has a zero offset inside its 2^L block has crossed a boundary and is treated as non-sequential.
- R5: With posting on, a non-sequential write, including the first write after reset, is accepted only in a cycle where the queue is empty. `host_ready` is high whenever the queue is empty.
- R6: With posting off, at most one word is held. `host_ready` rises in the cycle after that word's drain handshake, and the next write is only captured after that completion.
- R7: Words leave the drain port in acceptance order, each carrying its own address. While `drain_valid` is high and `drain_ready` is low, the address and data stay unchanged.
- R8: After reset the queue is empty and `drain_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| post_en | input | 1 | 1 enables posting; 0 selects the single-word mode |
| region_lg | input | REGIONS*5 | Log2 of each region's size in bytes, 5 bits per region |
| host_valid | input | 1 | Host write request |
| host_ready | output | 1 | Host write accepted this cycle when high together with host_valid |
| host_addr | input | 32 | Byte address of the write, word aligned |
| host_data | input | 32 | Write data |
| host_region | input | RW | Index of the region the write targets |
| drain_valid | output | 1 | A word is offered to the local side |
| drain_ready | input | 1 | Local side takes the offered word |
| drain_addr | output | 32 | Address of the offered word |
| drain_data | output | 32 | Data of the offered word |

## Verification
The bench sends random bursts that start at random offsets. Some of them run past the end of a small region, and some change the region index while keeping the address step. A design that tested only the address step would post across a boundary, and a design that stalled too late would drop or duplicate a word, which the scoreboard catches. The drain side holds off both at random and in long stretches, so the queue fills. A full-flag slip would then let a ninth word overwrite the oldest one or stall a write that still had room. In single-word mode the bench checks that each write finishes only after its own word has drained once, which catches a design that kept posting in this mode.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  localparam int WPB_AW = 32;
  localparam int WPB_DW = 32;

  typedef struct packed {
    logic [WPB_AW-1:0] addr;
    logic [WPB_DW-1:0] data;
  } wpb_entry_t;

  // Address the next write must carry to continue a run
  function automatic logic [WPB_AW-1:0] wpb_step(input logic [WPB_AW-1:0] a);
    return a + WPB_AW'(4);
  endfunction

  // True when the address sits at offset zero of its 2^lg byte block
  function automatic logic wpb_block_start(input logic [WPB_AW-1:0] a,
                                           input int unsigned lg);
    logic [WPB_AW-1:0] mask;
    if (lg < 2) return 1'b1;
    if (lg >= WPB_AW) mask = '1;
    else mask = (WPB_AW'(1) << lg) - WPB_AW'(1);
    return (a & mask) == '0;
  endfunction

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo
  import wpb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  wpb_entry_t din,
  input  logic       pop,
  output wpb_entry_t dout,
  output logic [CW-1:0] count,
  output logic       full,
  output logic       empty
);

  wpb_entry_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/wpb_accept.sv
module wpb_accept
  import wpb_pkg::*;
#(
  parameter int REGIONS = 4,
  parameter int LGW = 5,
  localparam int RW = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_en,
  input  logic [REGIONS*LGW-1:0] region_lg,
  input  logic               host_valid,
  input  logic [WPB_AW-1:0]  host_addr,
  input  logic [RW-1:0]      host_region,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  input  logic               drain_fire,
  output logic               host_ready,
  output logic               push,
  output logic               seq_hit
);

  // run tracking for posted mode
  logic              run_valid;
  logic [WPB_AW-1:0] last_addr;
  logic [RW-1:0]     last_region;
  logic [LGW-1:0]    lg_sel;

  // single-word mode: word captured, word drained
  logic np_hold, np_ack;

  logic post_accept, np_capture, host_fire;

  always_comb begin
    lg_sel = region_lg[int'(host_region)*LGW +: LGW];
  end

  assign seq_hit = run_valid
                && (host_addr == wpb_step(last_addr))
                && (host_region == last_region)
                && !wpb_block_start(host_addr, int'(lg_sel));

  assign post_accept = fifo_empty || (seq_hit && !fifo_full);
  assign np_capture  = !post_en && host_valid && !np_hold && fifo_empty;

  assign host_ready = post_en ? post_accept : np_ack;
  assign host_fire  = host_valid && host_ready;
  assign push       = post_en ? host_fire : np_capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_valid   <= 1'b0;
      last_addr   <= '0;
      last_region <= '0;
    end else if (!post_en) begin
      run_valid <= 1'b0;
    end else if (host_fire) begin
      run_valid   <= 1'b1;
      last_addr   <= host_addr;
      last_region <= host_region;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      np_hold <= 1'b0;
      np_ack  <= 1'b0;
    end else if (post_en) begin
      np_hold <= 1'b0;
      np_ack  <= 1'b0;
    end else begin
      if (np_capture) np_hold <= 1'b1;
      if (np_hold && drain_fire) np_ack <= 1'b1;
      if (np_ack && host_valid) begin
        np_hold <= 1'b0;
        np_ack  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wpost_buffer.sv
module wpost_buffer
  import wpb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int REGIONS = 4,
  localparam int LGW = 5,
  localparam int RW = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   post_en,
  input  logic [REGIONS*LGW-1:0] region_lg,
  input  logic                   host_valid,
  output logic                   host_ready,
  input  logic [WPB_AW-1:0]      host_addr,
  input  logic [WPB_DW-1:0]      host_data,
  input  logic [RW-1:0]          host_region,
  output logic                   drain_valid,
  input  logic                   drain_ready,
  output logic [WPB_AW-1:0]      drain_addr,
  output logic [WPB_DW-1:0]      drain_data
);

  // named internal events, used by the bound checker
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty, seq_hit;
  logic [CW-1:0] fifo_count;
  wpb_entry_t    in_entry, head;

  assign in_entry = '{addr: host_addr, data: host_data};
  assign drain_valid = !fifo_empty;
  assign fifo_pop    = drain_valid && drain_ready;
  assign drain_addr  = head.addr;
  assign drain_data  = head.data;

  wpb_accept #(.REGIONS(REGIONS), .LGW(LGW)) u_accept (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .region_lg(region_lg),
    .host_valid(host_valid), .host_addr(host_addr), .host_region(host_region),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .drain_fire(fifo_pop),
    .host_ready(host_ready), .push(fifo_push), .seq_hit(seq_hit)
  );

  wpb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(in_entry),
    .pop(fifo_pop), .dout(head), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

endmodule

// File: rtl/wpb_checker.sv
module wpb_checker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          post_en,
  input logic          host_valid,
  input logic          host_ready,
  input logic          seq_hit,
  input logic          fifo_push,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic          drain_valid,
  input logic          drain_ready,
  input logic [31:0]   drain_addr,
  input logic [31:0]   drain_data
);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    post_en && seq_hit && !fifo_full |-> host_ready);

  assert_break_drains_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    post_en && host_valid && host_ready && !seq_hit |-> fifo_count == '0);

  assert_single_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !post_en && fifo_count != '0 |-> !fifo_push);

  assert_done_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !post_en && host_ready |-> fifo_count == '0);

  assert_head_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && !drain_ready |=> drain_valid && $stable(drain_addr) && $stable(drain_data));

endmodule

bind wpost_buffer wpb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .post_en(post_en), .host_valid(host_valid),
  .host_ready(host_ready), .seq_hit(seq_hit), .fifo_push(fifo_push),
  .fifo_full(fifo_full), .fifo_count(fifo_count), .drain_valid(drain_valid),
  .drain_ready(drain_ready), .drain_addr(drain_addr), .drain_data(drain_data)
);

// File: tb/wpost_buffer_tb.sv
module wpost_buffer_tb;

  localparam int DEPTH = 8;
  localparam int NREG  = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        post_en = 1;
  logic [NREG*5-1:0] region_lg;
  logic        host_valid = 0;
  logic        host_ready;
  logic [31:0] host_addr = 0;
  logic [31:0] host_data = 0;
  logic [1:0]  host_region = 0;
  logic        drain_valid;
  logic        drain_ready = 0;
  logic [31:0] drain_addr, drain_data;

  int unsigned LG [NREG] = '{6, 7, 8, 12};

  always #2 clk = ~clk;   // 250 MHz

  wpost_buffer #(.DEPTH(DEPTH), .REGIONS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .region_lg(region_lg),
    .host_valid(host_valid), .host_ready(host_ready), .host_addr(host_addr),
    .host_data(host_data), .host_region(host_region),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_addr(drain_addr), .drain_data(drain_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit posted = 1;
  int drain_pct = 60;
  bit drain_stop = 0;

  logic [63:0] exp_q [$];

  // bench model of acceptance
  int          m_cnt = 0;
  bit          m_run = 0;
  logic [31:0] m_last = 0;
  logic [1:0]  m_reg = 0;
  bit          got_drain = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) region_lg[r*5 +: 5] = 5'(LG[r]);
  end

  // driver: drives one write, pushes the expected item when it is taken
  task automatic write_word(input logic [31:0] a, input logic [31:0] d, input logic [1:0] r);
    @(posedge clk); #1;
    host_valid = 1; host_addr = a; host_data = d; host_region = r;
    forever begin
      @(negedge clk);
      if (host_ready) begin
        if (posted) exp_q.push_back({a, d});
        break;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1; host_valid = 0;
    repeat (n) @(posedge clk);
  endtask

  // drain backpressure
  always @(posedge clk) begin
    #1;
    drain_ready <= !drain_stop && (($urandom % 100) < drain_pct);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit hf = host_valid && host_ready;
      automatic bit df = drain_valid && drain_ready;
      if (posted) begin
        automatic bit   blk = (LG[host_region] < 2) ||
                              ((host_addr & ((32'd1 << LG[host_region]) - 1)) == 0);
        automatic bit   step = m_run && (host_addr == m_last + 32'd4);
        automatic bit   seq  = step && (host_region == m_reg) && !blk;
        automatic bit   exp_rdy = (m_cnt == 0) || (seq && m_cnt < DEPTH);
        automatic string tag;
        if (m_cnt == 0) tag = "R5";
        else if (seq && m_cnt < DEPTH) tag = "R2";
        else if (seq) tag = "R1";
        else if (step && host_region == m_reg) tag = "R4";
        else tag = "R3";
        check(host_ready == exp_rdy, tag, "host_ready", 64'(host_ready), 64'(exp_rdy));
        if (df) begin
          if (exp_q.size() == 0)
            check(0, "R7", "drain with nothing queued", {drain_addr, drain_data}, 64'd0);
          else begin
            automatic logic [63:0] e = exp_q.pop_front();
            check({drain_addr, drain_data} == e, "R7", "drained word",
                  {drain_addr, drain_data}, e);
          end
        end
        if (hf) begin
          m_run = 1; m_last = host_addr; m_reg = host_region;
        end
        m_cnt = m_cnt + int'(hf) - int'(df);
      end else begin
        if (df) begin
          check(!got_drain, "R6", "second drain of one word", 64'(got_drain), 64'd0);
          check({drain_addr, drain_data} == {host_addr, host_data}, "R6",
                "single-word drain", {drain_addr, drain_data}, {host_addr, host_data});
          got_drain = 1;
        end
        if (hf) begin
          check(got_drain, "R6", "write completed before drain", 64'(got_drain), 64'd1);
          got_drain = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "R1", "watchdog expired", 64'd0, 64'd1);
      finish_run();
    end
  end

  task automatic wait_empty();
    @(posedge clk); #1; host_valid = 0;
    while (drain_valid) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    logic [31:0] a, base;
    logic [1:0]  r;
    int len, span;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(drain_valid == 0, "R8", "drain_valid in reset", 64'(drain_valid), 64'd0);
    #1 rst_n = 1;
    @(negedge clk);
    check(drain_valid == 0, "R8", "drain_valid after reset", 64'(drain_valid), 64'd0);
    check(host_ready == 1, "R5", "host_ready with empty queue", 64'(host_ready), 64'd1);

    // phase 1: random bursts, breaks and crossings (R2..R5, R7)
    a = 0; r = 0;
    for (int b = 0; b < 120; b++) begin
      drain_pct = (b % 3 == 0) ? 20 : 70;
      case ($urandom % 5)
        0: ;                                  // continue the run, maybe after a gap
        1: r = r + 2'd1;                       // region change, address keeps stepping
        default: begin
          r = 2'($urandom % NREG);
          base = 32'h1000_0000 * (r + 1);
          span = 1 << (LG[r] - 2);
          a = base + 32'(($urandom % span) * 4) - 32'd4;
        end
      endcase
      len = 1 + $urandom % 20;
      for (int i = 0; i < len; i++) begin
        a = a + 32'd4;
        write_word(a, $urandom, r);
      end
      if ($urandom % 4 == 0) idle(1 + $urandom % 6);
    end
    wait_empty();
    check(exp_q.size() == 0, "R7", "scoreboard empty", 64'(exp_q.size()), 64'd0);

    // phase 2: fill to 8 with the drain stopped (R1)
    drain_stop = 1;
    base = 32'h4000_0000 + 32'h100;
    fork
      for (int i = 0; i < 10; i++) write_word(base + 32'(i * 4), 32'hA5A5_0000 + 32'(i), 2'd3);
      begin
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(host_ready == 0, "R1", "ready with 8 queued", 64'(host_ready), 64'd0);
        check(m_cnt == DEPTH, "R1", "queued words", 64'(m_cnt), 64'(DEPTH));
        drain_stop = 0;
      end
    join
    wait_empty();
    check(exp_q.size() == 0, "R1", "all 10 words drained", 64'(exp_q.size()), 64'd0);

    // phase 3: posting disabled (R6)
    posted = 0; post_en = 0; drain_pct = 50;
    for (int i = 0; i < 25; i++)
      write_word(32'h1000_0000 + 32'(i * 4), $urandom, 2'd0);
    @(posedge clk); #1 host_valid = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(drain_valid == 0, "R6", "nothing left after last write", 64'(drain_valid), 64'd0);

    // phase 4: back to posting; first write must start a new run (R5)
    post_en = 1; m_run = 0; m_cnt = 0; posted = 1; drain_pct = 40;
    for (int i = 0; i < 30; i++)
      write_word(32'h2000_0000 + 32'h40 + 32'(i * 4), $urandom, 2'd1);
    wait_empty();
    check(exp_q.size() == 0, "R7", "final scoreboard empty", 64'(exp_q.size()), 64'd0);

    done = 1;
    finish_run();
  end

endmodule